// File: doc/BRIEF.md
# Single-Address Memory-Order Violation Monitor

This block watches a run-time stream of memory events that all target one shared location. Several processors issue these events. Each event carries the issuing processor number, a read/write kind and a data value. The block decides whether the observed values could have come from a memory that keeps reads and writes to one location in order. It relies on unambiguous data: no value is ever stored twice. Because of that, every value that is read identifies exactly one write.

Each accepted write is given a sequence number, in the order the writes arrive. A small associative table turns a value into its sequence number. Sequence number 0 stands for the location's initial value, which is supplied on a port. For each processor the block keeps the sequence number of the newest write that processor has read. A read that maps to an older write is a violation. So is a read of a value that was never stored. The first violation sets a sticky error flag and latches a 2-bit code. A write that breaks the unambiguous-data assumption sets a separate sticky flag and never sets the error flag.

Top module: `memory_order_monitor`

## Requirements
- R1: After reset, `err_flag` is 0, `err_code` is 2'b00 and `assume_broken` is 0.
- R2: A read that returns a value which is neither `init_value` nor any value stored so far is a violation with code 2'b01.
- R3: A processor that has read the value of write number s and later reads the value of a write numbered below s, but above 0, causes a violation with code 2'b10.
- R4: A processor that has read any stored value and later reads `init_value` causes a violation with code 2'b11.
- R5: Ordering is tracked per processor, so a processor may read an older value than another processor has already seen. A processor may also read back its own writes.
- R6: Writes never raise `err_flag`. Reading the same value again, or a newer one, raises nothing.
- R7: `err_flag` and `err_code` are sticky until reset. The code of the first violation is kept, and `err_code` is nonzero whenever `err_flag` is 1.
- R8: A write of a value that is already stored, a write of `init_value`, or a write when the table already holds `TABLE_DEPTH` values sets the sticky `assume_broken` flag. Such a write is not added to the write order and leaves `err_flag` unchanged.
- R9: All three outputs are registered. An event presented at a rising edge is reflected on the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_pid | input | $clog2(NUM_PROCS) | Issuing processor number |
| ev_is_write | input | 1 | 1 = write, 0 = read |
| ev_data | input | DATA_W | Value written or value returned |
| init_value | input | DATA_W | Initial content of the location, held stable |
| err_flag | output | 1 | Sticky memory-order violation flag |
| err_code | output | 2 | Code of the first violation: 01 never stored, 10 older write, 11 initial value again |
| assume_broken | output | 1 | Sticky flag: a write broke the unambiguous-data assumption |

## Verification
The bench sweeps every ordered pair of reads, including the initial value and a phantom value, taken after a run of increasing writes. A monitor that compared raw values rather than write order, or that allowed equal sequence numbers to fail, would disagree with the computed expectation on that grid. Separate cases check the following:
- Reads by two processors are independent, and a monitor with shared state would falsely flag the second processor.
- A writer can read its own store.
- A later violation must not overwrite the first code.
- Duplicate, initial-value and overflow writes set only the assumption flag.
- The one-cycle output latency holds.

// File: rtl/mom_pkg.sv
// Shared types for the memory-order monitor.
package mom_pkg;
    typedef enum logic [1:0] {
        VIOL_NONE    = 2'b00,
        VIOL_PHANTOM = 2'b01,
        VIOL_REORDER = 2'b10,
        VIOL_REVERT  = 2'b11
    } viol_e;
endpackage

// File: rtl/mom_value_table.sv
// Associative table from stored value to write sequence number.
// Entries fill in write order, so entry i holds write number i+1.
// Assumes the caller never inserts a value that already hits.
module mom_value_table #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int SEQ_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic [DATA_W-1:0] key,
    output logic              hit,
    output logic [SEQ_W-1:0]  hit_seq,
    output logic              full
);
    logic [SEQ_W-1:0]  fill_cnt;
    logic [DATA_W-1:0] slot_val [DEPTH];
    logic [DEPTH-1:0]  slot_match;

    assign full = (fill_cnt == SEQ_W'(DEPTH));

    // Fill counter: number of stored values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (ins_en && !full) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot storage: captured when this slot is the next free one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_val[i] <= '0;
            end else if (ins_en && !full && fill_cnt == SEQ_W'(i)) begin
                slot_val[i] <= key;
            end
        end
        // Slot compare: occupied and equal to the key.
        assign slot_match[i] = (SEQ_W'(i) < fill_cnt) && (slot_val[i] == key);
    end

    // Encoder: turn the matching slot into its write number.
    always_comb begin
        hit     = 1'b0;
        hit_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_match[i] && !hit) begin
                hit     = 1'b1;
                hit_seq = SEQ_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/mom_reader_track.sv
// Per-processor record of the newest write number each processor has read.
// 0 means only the initial value has been seen.
module mom_reader_track #(
    parameter int NPROC = 4,
    parameter int SEQ_W = 5,
    parameter int PID_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] pid,
    input  logic             upd_en,
    input  logic [SEQ_W-1:0] upd_seq,
    output logic [SEQ_W-1:0] last_seq
);
    logic [SEQ_W-1:0] seen [NPROC];

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        // Record: advance this processor's newest observed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen[p] <= '0;
            end else if (upd_en && pid == PID_W'(p)) begin
                seen[p] <= upd_seq;
            end
        end
    end

    // Select: the record of the processor issuing the current event.
    always_comb begin
        last_seq = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (pid == PID_W'(p)) last_seq = seen[p];
        end
    end
endmodule

// File: rtl/mom_classify.sv
// Combinational classification of one read against the reader's history.
// Assumes the key never hits the table and equals the initial value together.
module mom_classify #(
    parameter int SEQ_W = 5
) (
    input  logic             is_read,
    input  logic             hit,
    input  logic [SEQ_W-1:0] hit_seq,
    input  logic             is_init,
    input  logic [SEQ_W-1:0] last_seq,
    output mom_pkg::viol_e   viol,
    output logic             adv_en,
    output logic [SEQ_W-1:0] adv_seq
);
    import mom_pkg::*;

    // Decide: map the read to a write number and compare with history.
    always_comb begin
        viol    = VIOL_NONE;
        adv_en  = 1'b0;
        adv_seq = '0;
        if (is_read) begin
            if (hit) begin
                if (hit_seq < last_seq) begin
                    viol = VIOL_REORDER;
                end else begin
                    adv_en  = 1'b1;
                    adv_seq = hit_seq;
                end
            end else if (is_init) begin
                if (last_seq != '0) viol = VIOL_REVERT;
            end else begin
                viol = VIOL_PHANTOM;
            end
        end
    end
endmodule

// File: rtl/memory_order_monitor.sv
// Run-time monitor of read/write events to one shared location.
// It flags reads that no memory keeping per-location order could return.
// Assumes that every stored value is unique and that init_value is stable.
module memory_order_monitor #(
    parameter int NUM_PROCS   = 4,
    parameter int DATA_W      = 8,
    parameter int TABLE_DEPTH = 16,
    localparam int PID_W      = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
    localparam int SEQ_W      = $clog2(TABLE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [PID_W-1:0]  ev_pid,
    input  logic              ev_is_write,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [DATA_W-1:0] init_value,
    output logic              err_flag,
    output logic [1:0]        err_code,
    output logic              assume_broken
);
    import mom_pkg::*;

    logic             lk_hit;
    logic [SEQ_W-1:0] lk_seq;
    logic             tbl_full;
    logic             is_init_val;
    logic             wr_ev;
    logic             rd_ev;
    logic             wr_accept;
    logic             wr_bad;
    logic [SEQ_W-1:0] rd_last;
    viol_e            rd_viol;
    logic             adv_en;
    logic [SEQ_W-1:0] adv_seq;

    assign is_init_val = (ev_data == init_value);
    assign wr_ev       = ev_valid && ev_is_write;
    assign rd_ev       = ev_valid && !ev_is_write;
    assign wr_bad      = wr_ev && (lk_hit || is_init_val || tbl_full);
    assign wr_accept   = wr_ev && !wr_bad;

    mom_value_table #(
        .DEPTH  (TABLE_DEPTH),
        .DATA_W (DATA_W),
        .SEQ_W  (SEQ_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_en  (wr_accept),
        .key     (ev_data),
        .hit     (lk_hit),
        .hit_seq (lk_seq),
        .full    (tbl_full)
    );

    mom_reader_track #(
        .NPROC (NUM_PROCS),
        .SEQ_W (SEQ_W),
        .PID_W (PID_W)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pid      (ev_pid),
        .upd_en   (adv_en),
        .upd_seq  (adv_seq),
        .last_seq (rd_last)
    );

    mom_classify #(
        .SEQ_W (SEQ_W)
    ) classify_i (
        .is_read  (rd_ev),
        .hit      (lk_hit),
        .hit_seq  (lk_seq),
        .is_init  (is_init_val),
        .last_seq (rd_last),
        .viol     (rd_viol),
        .adv_en   (adv_en),
        .adv_seq  (adv_seq)
    );

    // Error latch: capture the first violation and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= 2'b00;
        end else if (!err_flag && rd_viol != VIOL_NONE) begin
            err_flag <= 1'b1;
            err_code <= rd_viol;
        end
    end

    // Assumption latch: sticky once a write breaks value uniqueness or capacity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assume_broken <= 1'b0;
        end else if (wr_bad) begin
            assume_broken <= 1'b1;
        end
    end
endmodule

// File: rtl/mom_checker.sv
// Property checker for memory_order_monitor, attached by bind.
module mom_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic       ev_is_write,
    input logic       lk_hit,
    input logic       is_init_val,
    input logic       err_flag,
    input logic [1:0] err_code,
    input logic       assume_broken
);
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> err_code != 2'b00); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R7
    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> $stable(err_code)); // R7
    AST_BROKEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        assume_broken |=> assume_broken); // R8
    AST_DUP_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_is_write && lk_hit |=> assume_broken); // R8
    AST_PHANTOM_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_is_write && !lk_hit && !is_init_val && !err_flag
        |=> err_flag && err_code == 2'b01); // R2
    AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_is_write && !err_flag |=> !err_flag); // R6
endmodule

bind memory_order_monitor mom_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid      (ev_valid),
    .ev_is_write   (ev_is_write),
    .lk_hit        (lk_hit),
    .is_init_val   (is_init_val),
    .err_flag      (err_flag),
    .err_code      (err_code),
    .assume_broken (assume_broken)
);

// File: tb/memory_order_monitor_tb_top.sv
`timescale 1ns/1ps
module memory_order_monitor_tb_top;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int TD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_pid = '0;
    logic          ev_is_write = 1'b0;
    logic [DW-1:0] ev_data = '0;
    logic [DW-1:0] init_value = '0;
    logic          err_flag;
    logic [1:0]    err_code;
    logic          assume_broken;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    memory_order_monitor #(.NUM_PROCS(NP), .DATA_W(DW), .TABLE_DEPTH(TD)) dut_i (
        .clk (clk), .rst_n (rst_n), .ev_valid (ev_valid), .ev_pid (ev_pid),
        .ev_is_write (ev_is_write), .ev_data (ev_data), .init_value (init_value),
        .err_flag (err_flag), .err_code (err_code), .assume_broken (assume_broken)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [DW-1:0] init);
        @(negedge clk);
        rst_n = 1'b0;
        ev_valid = 1'b0;
        init_value = init;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one event at the next rising edge; returns at the following falling edge.
    task automatic send(input int pid, input logic wr, input int data);
        ev_valid = 1'b1;
        ev_pid = 2'(pid);
        ev_is_write = wr;
        ev_data = DW'(data);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    initial begin
        int exp_code;
        do_reset(8'd0);
        // R1 reset state
        check("R1 err_flag", int'(err_flag), 0);
        check("R1 err_code", int'(err_code), 0);
        check("R1 assume_broken", int'(assume_broken), 0);

        // Sweep: writes 1..4 by pid0, then pid1 reads a then b (0 = initial, 5 = phantom)
        for (int a = 0; a <= 5; a++) begin
            for (int b = 0; b <= 5; b++) begin
                do_reset(8'd0);
                for (int w = 1; w <= 4; w++) send(0, 1'b1, w);
                send(1, 1'b0, a);
                send(1, 1'b0, b);
                if (a == 5 || b == 5) exp_code = 1;       // R2
                else if (b < a && b == 0) exp_code = 3;   // R4
                else if (b < a) exp_code = 2;             // R3
                else exp_code = 0;                        // R6
                check("R2/R3/R4/R6 sweep code", int'(err_code), exp_code);
                check("R7 sweep flag", int'(err_flag), (exp_code != 0) ? 1 : 0);
            end
        end

        // R5: per-processor independence, no violation
        do_reset(8'd0);
        for (int w = 1; w <= 3; w++) send(0, 1'b1, w);
        send(1, 1'b0, 3);
        send(2, 1'b0, 1);
        send(3, 1'b0, 0);
        check("R5 independent readers", int'(err_flag), 0);

        // R5: a writer reading its own stores, then an older one
        do_reset(8'd0);
        send(2, 1'b1, 1);
        send(2, 1'b0, 1);
        send(2, 1'b1, 2);
        send(2, 1'b0, 2);
        check("R5 own reads ok", int'(err_flag), 0);
        send(2, 1'b0, 1);
        check("R5 own older read", int'(err_code), 2);

        // R7: a later violation keeps the first code
        send(3, 1'b0, 99);
        check("R7 first code kept", int'(err_code), 2);
        check("R7 flag held", int'(err_flag), 1);

        // R4 with a nonzero initial value
        do_reset(8'd7);
        send(1, 1'b0, 7);
        send(0, 1'b1, 1);
        send(1, 1'b0, 1);
        check("R4 no error yet", int'(err_flag), 0);
        send(1, 1'b0, 7);
        check("R4 revert code", int'(err_code), 3);

        // R8: duplicate write
        do_reset(8'd0);
        send(0, 1'b1, 3);
        send(1, 1'b1, 3);
        check("R8 duplicate broken", int'(assume_broken), 1);
        check("R8 duplicate no err", int'(err_flag), 0);
        // R8: a rejected duplicate is not added to the order; reading it stays legal
        send(1, 1'b0, 3);
        check("R8 read after dup", int'(err_flag), 0);

        // R8: write of the initial value
        do_reset(8'd0);
        send(0, 1'b1, 0);
        check("R8 init write broken", int'(assume_broken), 1);
        send(1, 1'b0, 0);
        check("R8 init write not stored", int'(err_flag), 0);

        // R8: table overflow; the rejected value reads back as phantom
        do_reset(8'd0);
        for (int w = 1; w <= TD; w++) send(0, 1'b1, w);
        check("R8 full not broken", int'(assume_broken), 0);
        send(1, 1'b0, TD);
        check("R8 last slot readable", int'(err_flag), 0);
        send(0, 1'b1, TD + 1);
        check("R8 overflow broken", int'(assume_broken), 1);
        send(1, 1'b0, TD + 1);
        check("R8 overflow not stored", int'(err_code), 1);

        // R9: output changes only after the event's edge
        do_reset(8'd0);
        ev_valid = 1'b1;
        ev_pid = 2'd1;
        ev_is_write = 1'b0;
        ev_data = 8'd42;
        check("R9 before edge", int'(err_flag), 0);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        check("R9 after edge", int'(err_flag), 1);
        check("R9 code", int'(err_code), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule